// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block makes the word address for each beat of a four-beat memory burst. A starting address is captured on a rising clock edge when either of two active-low address strobes asks for it. The controller-side strobe loads on its own. The host-side strobe loads only while the active-low chip enable is also low. After a load, the two low address bits step through the burst whenever the active-low step input is low, and they hold while it is high. The upper address bits stay as loaded.

A static order input picks how the low bits move. When it is low, the order is linear: the start plus the beat count, wrapping within four words. When it is high, the order is interleaved: the start XORed with the beat count. The outputs are the current full address and the two-bit beat index. Both come straight from registers, so a load is visible right after the edge that captured it. The block has no data path, so it has no valid/ready flow control. All pins are plain control and status pins, and nothing downstream can stall it.

Top module: `burst_addr_gen`

## Requirements
- R1: When ctl_strobe_n is low at a rising edge, the address is loaded from addr_in, whatever chip_en_n is.
- R2: When host_strobe_n and chip_en_n are both low at a rising edge, the address is loaded from addr_in.
- R3: When host_strobe_n is low but chip_en_n is high, and no other load happens, host_strobe_n has no effect. With step_n high, addr_out and beat stay unchanged.
- R4: At an edge with no load and step_n low, beat advances by one modulo 4, so 3 is followed by 0.
- R5: At an edge with no load and step_n high, both addr_out and beat hold their values.
- R6: With order_sel low (linear), addr_out[1:0] equals (start[1:0] + beat) mod 4.
- R7: With order_sel high (interleaved), addr_out[1:0] equals start[1:0] XOR beat.
- R8: Between loads, addr_out[ADDR_W-1:2] stays at the loaded value. Stepping past the fourth beat wraps within the same four-word group.
- R9: A load in the same cycle as step_n low takes priority: beat becomes 0 and addr_out equals addr_in.
- R10: After reset, addr_out is 0 and beat is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | ADDR_W (19) | Starting word address |
| ctl_strobe_n | input | 1 | Active-low load strobe, not qualified by chip enable |
| host_strobe_n | input | 1 | Active-low load strobe, qualified by chip_en_n |
| chip_en_n | input | 1 | Active-low chip enable that gates host_strobe_n |
| step_n | input | 1 | Active-low advance; high holds the burst position |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved (XOR) order; static |
| addr_out | output | ADDR_W (19) | Address of the current beat |
| beat | output | 2 | Beat index, 0 to 3 |

## Verification
The hold and upper-bit assertions assume that order_sel is static: it changes only in a cycle where a load also happens, so the address never moves during a hold. The stimulus changes the order input only together with a strobe that causes a load. All other inputs are driven on the falling edge, so they are settled at each rising edge. Reset is released on a falling edge, and every property is disabled while reset is low.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_load_qual.sv
module burst_load_qual (
  input  logic ctl_strobe_n,
  input  logic host_strobe_n,
  input  logic chip_en_n,
  output logic load
);
  // host strobe is honoured only with chip enable asserted
  always_comb load = ~ctl_strobe_n | (~host_strobe_n & ~chip_en_n);
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  output logic [BEAT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= '0;
    else if (adv)  cnt <= cnt + 1'b1;
  end

  assert_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> (cnt == BEAT_W'($past(cnt) + 1'b1)));

  assert_load_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == '0));
endmodule

// File: rtl/burst_order.sv
module burst_order
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              order_sel,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] cnt,
  output logic [BEAT_W-1:0] low_addr
);
  order_e mode;
  always_comb begin
    mode = order_e'(order_sel);
    case (mode)
      ORDER_XOR: low_addr = start ^ cnt;
      default:   low_addr = start + cnt;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr_in,
  input  logic                       ctl_strobe_n,
  input  logic                       host_strobe_n,
  input  logic                       chip_en_n,
  input  logic                       step_n,
  input  logic                       order_sel,
  output logic [ADDR_W-1:0]          addr_out,
  output logic [$clog2(BURST_LEN)-1:0] beat
);
  localparam int BEAT_W = $clog2(BURST_LEN);
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt;
  logic [BEAT_W-1:0] low_addr;

  burst_load_qual u_qual (
    .ctl_strobe_n (ctl_strobe_n),
    .host_strobe_n(host_strobe_n),
    .chip_en_n    (chip_en_n),
    .load         (load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= addr_in;
  end

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .adv  (~step_n),
    .cnt  (cnt)
  );

  burst_order #(.BEAT_W(BEAT_W)) u_order (
    .order_sel(order_sel),
    .start    (base_q[BEAT_W-1:0]),
    .cnt      (cnt),
    .low_addr (low_addr)
  );

  assign addr_out = {base_q[ADDR_W-1:BEAT_W], low_addr};
  assign beat     = cnt;

  assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_out == $past(addr_in)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> ($stable(addr_out) && $stable(beat)));

  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

  assert_gated_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_strobe_n && chip_en_n && step_n) |=> $stable(addr_out));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 19;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    beat;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic ctl_strobe_n = 1'b1, host_strobe_n = 1'b1, chip_en_n = 1'b1;
  logic step_n = 1'b1, order_sel = 1'b0;
  logic [AW-1:0] addr_out;
  logic [1:0] beat;

  int checks = 0;
  int fails = 0;
  exp_t q[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_mode = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .ctl_strobe_n(ctl_strobe_n), .host_strobe_n(host_strobe_n),
    .chip_en_n(chip_en_n), .step_n(step_n), .order_sel(order_sel),
    .addr_out(addr_out), .beat(beat)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    lo = m_mode ? (m_base[1:0] ^ m_beat) : 2'(m_base[1:0] + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(logic [AW-1:0] a, logic [1:0] b, exp_t e);
    checks++;
    if (a !== e.addr || b !== e.beat) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               e.tag, a, b, e.addr, e.beat);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed for the monitor
  task automatic drive(logic cs, logic hs, logic ce, logic st, logic md,
                       logic [AW-1:0] a, string tag);
    exp_t e;
    @(negedge clk);
    ctl_strobe_n = cs; host_strobe_n = hs; chip_en_n = ce;
    step_n = st; order_sel = md; addr_in = a;
    m_mode = md;
    if (!cs || (!hs && !ce)) begin
      m_base = a; m_beat = 2'd0;
    end else if (!st) begin
      m_beat = m_beat + 2'd1;
    end
    e.addr = model_addr(); e.beat = m_beat; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) check(addr_out, beat, q.pop_front());
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    exp_t e;
    #3;
    e.addr = '0; e.beat = '0; e.tag = "R10";
    check(addr_out, beat, e);
    @(negedge clk); rst_n = 1'b1;

    drive(0, 1, 1, 1, 0, 19'h1A5F2, "R1 ctl load, chip enable high");
    for (int i = 0; i < 6; i++) drive(1, 1, 1, 0, 0, '0, "R4 R6 R8 linear step wrap");
    drive(1, 1, 1, 1, 0, 19'h7FFFF, "R5 hold");
    drive(1, 1, 1, 1, 0, 19'h00000, "R5 hold again");
    drive(1, 0, 0, 1, 1, 19'h3C4D1, "R2 host load with enable");
    for (int i = 0; i < 5; i++) drive(1, 1, 1, 0, 1, '0, "R7 R8 interleaved step");
    drive(1, 0, 1, 1, 1, 19'h55555, "R3 host strobe without enable");
    drive(1, 0, 1, 0, 1, 19'h55555, "R3 gated host strobe, step proceeds");
    drive(0, 1, 1, 0, 1, 19'h0ABC3, "R9 load beats step");
    for (int i = 0; i < 4; i++) drive(1, 1, 0, 0, 1, '0, "R7 interleaved start 3");
    drive(1, 0, 0, 0, 0, 19'h7FFFE, "R9 R2 host load with step");
    for (int i = 0; i < 5; i++) drive(1, 1, 0, 0, 0, '0, "R6 R8 linear start 2 top");
    drive(1, 1, 1, 1, 0, '0, "R5 final hold");
    @(negedge clk); @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule